// File: doc/BRIEF.md
# Switch Address Table Controller

This block holds the learned forwarding entries of a small Ethernet switch and lets management software maintain them. Each entry carries a 48-bit MAC address, a 12-bit VLAN ID, a 3-bit filter ID, an independent-VLAN-learning bit, an 8-bit port map, an 8-bit age timer and a 2-bit status. Status 0 means the slot is empty, status 3 pins the entry as static, and statuses 1 and 2 are dynamic entries that age out.

Software issues one command at a time on a 4-bit code with an index and write data. It then waits for the busy flag to drop and reads the result outputs and flags. Besides single-entry read and write, the controller can flush all dynamic entries and can walk the table with a start/continue search that reports one occupied entry per step. A background prescaler produces an ageing tick every (unit + 1) idle cycles. Each tick counts down the timer of every dynamic entry, and an entry whose timer runs out is removed.

Top module: `atab_top`

## Requirements
- R1: After reset, busy, searchHit, searchEnd and invalidFlag are 0 and every entry is empty, so a search-start walks the whole table and finishes with searchEnd=1 and searchHit=0 after ENTRIES+1 busy cycles.
- R2: Command codes on cmdCode are read=0, write=1, flush=2, search-start=4, search-next=5. Any other code leaves the table untouched and raises invalidFlag after one busy cycle.
- R3: A command presented while busy is 0 is accepted on that clock edge, and busy is 1 from the next cycle until the command ends. Read and write keep busy high for exactly one cycle.
- R4: A command presented while busy is 1 is ignored.
- R5: Write stores the MAC, VLAN, filter ID, learning bit, port map and status at cmdIndex, and loads the age timer from ageCount. Read returns all fields of the entry at cmdIndex and sets resIndex. Reading an empty entry (status 0) sets invalidFlag.
- R6: Search-start examines entries from index 0 upward, one per cycle. It stops at the first non-empty entry with searchHit=1, returns that entry and puts its index on resIndex.
- R7: Search-next resumes at the index after the last hit. When the walk passes the last index, searchEnd=1 and searchHit=0.
- R8: Flush empties every entry whose status is not 3, keeps static entries intact, and holds busy for exactly ENTRIES cycles.
- R9: While ageDisable=0 and the controller is idle, a tick occurs every ageUnit+1 cycles. On each tick, every entry with status 1 or 2 has its age decremented, and an entry at age 1 or 0 becomes empty. Static entries are not touched.
- R10: While ageDisable=1, no ageing occurs and the tick prescaler is held at zero.
- R11: searchHit and searchEnd are never both 1, and all three flags are cleared when a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdCode | input | 4 | Command code |
| cmdIndex | input | IDXW | Entry index for read/write |
| wrMac | input | 48 | MAC address to write |
| wrVid | input | 12 | VLAN ID to write |
| wrFid | input | 3 | Filter ID to write |
| wrIvl | input | 1 | Independent VLAN learning bit to write |
| wrPortMap | input | 8 | Port map to write |
| wrStatus | input | 2 | Entry status to write |
| ageDisable | input | 1 | Stops ageing when 1 |
| ageCount | input | 8 | Age timer load value for writes |
| ageUnit | input | 12 | Tick period minus one, in cycles |
| busy | output | 1 | Command in progress |
| searchEnd | output | 1 | Search walked past the last entry |
| searchHit | output | 1 | Search found an entry |
| invalidFlag | output | 1 | Empty entry read or unknown command |
| resIndex | output | IDXW | Index of the returned entry |
| rdMac | output | 48 | Returned MAC address |
| rdVid | output | 12 | Returned VLAN ID |
| rdFid | output | 3 | Returned filter ID |
| rdIvl | output | 1 | Returned learning bit |
| rdPortMap | output | 8 | Returned port map |
| rdAge | output | 8 | Returned age timer |
| rdStatus | output | 2 | Returned entry status |

## Verification
Some table faults stay hidden until software touches the slot, because no output shows the table directly. A corrupted entry or a wrong age count only appears on the next read of that index, or when a search walk lands on it. The bench therefore reads back every affected index right after each write, ageing window and flush. A wrong scan pointer shows at once as a busy length or resIndex that differs from the count of entries examined. A prescaler off by one shows as a timer value that differs after a fixed number of idle cycles.

// File: rtl/atab_pkg.sv
package atab_pkg;
  typedef struct packed {
    logic [47:0] mac;
    logic [11:0] vid;
    logic [2:0]  fid;
    logic        ivl;
    logic [7:0]  portMap;
    logic [7:0]  age;
    logic [1:0]  status;
  } entry_t;

  localparam logic [3:0] CMD_READ  = 4'd0;
  localparam logic [3:0] CMD_WRITE = 4'd1;
  localparam logic [3:0] CMD_FLUSH = 4'd2;
  localparam logic [3:0] CMD_START = 4'd4;
  localparam logic [3:0] CMD_NEXT  = 4'd5;

  localparam logic [1:0] ST_EMPTY  = 2'd0;
  localparam logic [1:0] ST_STATIC = 2'd3;

  typedef struct packed {
    logic latch;
    logic wrEn;
    logic clrEn;
    logic capEn;
    logic ageTick;
  } strobe_t;
endpackage

// File: rtl/atab_ctrl.sv
module atab_ctrl
  import atab_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [3:0]      cmdCode,
  input  logic [IDXW-1:0] cmdIndex,
  input  logic [1:0]      curStatus,
  input  logic            ageDisable,
  input  logic [11:0]     ageUnit,
  output strobe_t         stb,
  output logic [IDXW-1:0] idx,
  output logic            busy,
  output logic            searchEnd,
  output logic            searchHit,
  output logic            invalidFlag,
  output logic [IDXW-1:0] resIndex
);
  localparam int PTRW = IDXW + 1;
  localparam logic [PTRW-1:0] LAST_P = PTRW'(ENTRIES - 1);
  localparam logic [PTRW-1:0] END_P  = PTRW'(ENTRIES);

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_SWEEP, S_SCAN} state_t;

  state_t          state;
  logic [3:0]      op;
  logic [IDXW-1:0] latIdx;
  logic [PTRW-1:0] ptr;
  logic [PTRW-1:0] nextPtr;
  logic [11:0]     prescale;
  logic            ptrInRange;

  assign ptrInRange = (ptr < END_P);
  assign idx = (state == S_EXEC) ? latIdx : ptr[IDXW-1:0];

  always_comb begin
    stb = '0;
    stb.latch   = (state == S_IDLE) && cmdValid;
    stb.wrEn    = (state == S_EXEC) && (op == CMD_WRITE);
    stb.clrEn   = (state == S_SWEEP) && (curStatus != ST_STATIC);
    stb.capEn   = ((state == S_EXEC) && (op == CMD_READ)) ||
                  ((state == S_SCAN) && ptrInRange && (curStatus != ST_EMPTY));
    stb.ageTick = (state == S_IDLE) && !ageDisable && (prescale == ageUnit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      op          <= '0;
      latIdx      <= '0;
      ptr         <= '0;
      nextPtr     <= '0;
      prescale    <= '0;
      busy        <= 1'b0;
      searchEnd   <= 1'b0;
      searchHit   <= 1'b0;
      invalidFlag <= 1'b0;
      resIndex    <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (ageDisable || stb.ageTick) prescale <= '0;
          else prescale <= prescale + 12'd1;
          if (cmdValid) begin
            busy        <= 1'b1;
            searchEnd   <= 1'b0;
            searchHit   <= 1'b0;
            invalidFlag <= 1'b0;
            op          <= cmdCode;
            latIdx      <= cmdIndex;
            unique case (cmdCode)
              CMD_FLUSH: begin state <= S_SWEEP; ptr <= '0; end
              CMD_START: begin state <= S_SCAN; ptr <= '0; end
              CMD_NEXT:  begin state <= S_SCAN; ptr <= nextPtr; end
              default:   state <= S_EXEC;
            endcase
          end
        end
        S_EXEC: begin
          busy  <= 1'b0;
          state <= S_IDLE;
          if (op == CMD_READ) begin
            invalidFlag <= (curStatus == ST_EMPTY);
            resIndex    <= latIdx;
          end else if (op != CMD_WRITE) begin
            invalidFlag <= 1'b1;
          end
        end
        S_SWEEP: begin
          if (ptr == LAST_P) begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            ptr <= ptr + PTRW'(1);
          end
        end
        S_SCAN: begin
          if (!ptrInRange) begin
            searchEnd <= 1'b1;
            nextPtr   <= END_P;
            busy      <= 1'b0;
            state     <= S_IDLE;
          end else if (curStatus != ST_EMPTY) begin
            searchHit <= 1'b1;
            resIndex  <= ptr[IDXW-1:0];
            nextPtr   <= ptr + PTRW'(1);
            busy      <= 1'b0;
            state     <= S_IDLE;
          end else begin
            ptr <= ptr + PTRW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atab_store.sv
module atab_store
  import atab_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [IDXW-1:0] idx,
  input  entry_t          wrData,
  output logic [1:0]      curStatus,
  output entry_t          rdEntry
);
  localparam logic [IDXW:0] NENT = (IDXW + 1)'(ENTRIES);

  entry_t tbl [ENTRIES];
  entry_t wrHold;
  logic   idxOk;

  assign idxOk = ({1'b0, idx} < NENT);
  assign curStatus = idxOk ? tbl[idx].status : ST_EMPTY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrHold  <= '0;
      rdEntry <= '0;
    end else begin
      if (stb.latch) wrHold <= wrData;
      if (stb.capEn && idxOk) rdEntry <= tbl[idx];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hitMe;
    logic dynamic;
    assign hitMe   = (idx == IDXW'(g));
    assign dynamic = (tbl[g].status != ST_EMPTY) && (tbl[g].status != ST_STATIC);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tbl[g] <= '0;
      end else if (stb.wrEn && hitMe) begin
        tbl[g] <= wrHold;
      end else if (stb.clrEn && hitMe) begin
        tbl[g] <= '0;
      end else if (stb.ageTick && dynamic) begin
        if (tbl[g].age <= 8'd1) begin
          tbl[g].age    <= '0;
          tbl[g].status <= ST_EMPTY;
        end else begin
          tbl[g].age <= tbl[g].age - 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/atab_top.sv
module atab_top
  import atab_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDXW = ($clog2(ENTRIES) > 0) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [3:0]      cmdCode,
  input  logic [IDXW-1:0] cmdIndex,
  input  logic [47:0]     wrMac,
  input  logic [11:0]     wrVid,
  input  logic [2:0]      wrFid,
  input  logic            wrIvl,
  input  logic [7:0]      wrPortMap,
  input  logic [1:0]      wrStatus,
  input  logic            ageDisable,
  input  logic [7:0]      ageCount,
  input  logic [11:0]     ageUnit,
  output logic            busy,
  output logic            searchEnd,
  output logic            searchHit,
  output logic            invalidFlag,
  output logic [IDXW-1:0] resIndex,
  output logic [47:0]     rdMac,
  output logic [11:0]     rdVid,
  output logic [2:0]      rdFid,
  output logic            rdIvl,
  output logic [7:0]      rdPortMap,
  output logic [7:0]      rdAge,
  output logic [1:0]      rdStatus
);
  strobe_t         stb;
  logic [IDXW-1:0] idx;
  logic [1:0]      curStatus;
  entry_t          wrData;
  entry_t          rdEntry;

  assign wrData = '{mac: wrMac, vid: wrVid, fid: wrFid, ivl: wrIvl,
                    portMap: wrPortMap, age: ageCount, status: wrStatus};

  atab_ctrl #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdIndex(cmdIndex), .curStatus(curStatus), .ageDisable(ageDisable),
    .ageUnit(ageUnit), .stb(stb), .idx(idx), .busy(busy),
    .searchEnd(searchEnd), .searchHit(searchHit),
    .invalidFlag(invalidFlag), .resIndex(resIndex)
  );

  atab_store #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .wrData(wrData),
    .curStatus(curStatus), .rdEntry(rdEntry)
  );

  assign rdMac     = rdEntry.mac;
  assign rdVid     = rdEntry.vid;
  assign rdFid     = rdEntry.fid;
  assign rdIvl     = rdEntry.ivl;
  assign rdPortMap = rdEntry.portMap;
  assign rdAge     = rdEntry.age;
  assign rdStatus  = rdEntry.status;
endmodule

// File: rtl/atab_checker.sv
module atab_checker #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic            busy,
  input logic            searchEnd,
  input logic            searchHit,
  input logic            invalidFlag,
  input logic [IDXW-1:0] resIndex,
  input logic [1:0]      rdStatus
);
  assert_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid) |=> busy);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdValid) |=> ($stable(searchHit) && $stable(searchEnd) &&
                              $stable(invalidFlag) && $stable(resIndex)));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(searchHit && searchEnd));

  assert_flags_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!searchHit && !searchEnd && !invalidFlag));

  assert_hit_nonempty_R6: assert property (@(posedge clk) disable iff (!rstN)
    searchHit |-> (rdStatus != 2'd0));
endmodule

bind atab_top atab_checker #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busy(busy),
  .searchEnd(searchEnd), .searchHit(searchHit), .invalidFlag(invalidFlag),
  .resIndex(resIndex), .rdStatus(rdStatus)
);

// File: tb/sim_atab_top.sv
module sim_atab_top;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;
  localparam int IDXW = 3;
  localparam logic [3:0] C_RD = 4'd0, C_WR = 4'd1, C_FL = 4'd2, C_ST = 4'd4, C_NX = 4'd5;

  // vector: {index, mac, vid, portMap, status}
  localparam int NVEC = 4;
  localparam logic [72:0] VEC [NVEC] = '{
    {3'd1, 48'h0011_2233_4455, 12'h00A, 8'h03, 2'd1},
    {3'd3, 48'hA0B1_C2D3_E4F5, 12'h123, 8'h40, 2'd3},
    {3'd4, 48'h0200_0000_0001, 12'hFFE, 8'h81, 2'd2},
    {3'd6, 48'hDEAD_BEEF_0606, 12'h7C0, 8'h10, 2'd1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] cmdCode = '0;
  logic [IDXW-1:0] cmdIndex = '0;
  logic [47:0] wrMac = '0;
  logic [11:0] wrVid = '0;
  logic [2:0] wrFid = 3'd5;
  logic wrIvl = 1'b1;
  logic [7:0] wrPortMap = '0;
  logic [1:0] wrStatus = '0;
  logic ageDisable = 1'b1;
  logic [7:0] ageCount = 8'h20;
  logic [11:0] ageUnit = 12'd3;
  logic busy, searchEnd, searchHit, invalidFlag;
  logic [IDXW-1:0] resIndex;
  logic [47:0] rdMac;
  logic [11:0] rdVid;
  logic [2:0] rdFid;
  logic rdIvl;
  logic [7:0] rdPortMap, rdAge;
  logic [1:0] rdStatus;

  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atab_top #(.ENTRIES(ENTRIES)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdIndex(cmdIndex), .wrMac(wrMac), .wrVid(wrVid), .wrFid(wrFid),
    .wrIvl(wrIvl), .wrPortMap(wrPortMap), .wrStatus(wrStatus),
    .ageDisable(ageDisable), .ageCount(ageCount), .ageUnit(ageUnit),
    .busy(busy), .searchEnd(searchEnd), .searchHit(searchHit),
    .invalidFlag(invalidFlag), .resIndex(resIndex), .rdMac(rdMac),
    .rdVid(rdVid), .rdFid(rdFid), .rdIvl(rdIvl), .rdPortMap(rdPortMap),
    .rdAge(rdAge), .rdStatus(rdStatus)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] code, input int idx, output int cyc);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code; cmdIndex = idx[IDXW-1:0];
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 hit", searchHit, 0);
    chk("R1 end", searchEnd, 0);
    chk("R1 invalid", invalidFlag, 0);
    issue(C_ST, 0, cyc);
    chk("R1 empty scan end", searchEnd, 1);
    chk("R1 empty scan hit", searchHit, 0);
    chk("R1 empty scan cycles", cyc, ENTRIES + 1);

    for (int v = 0; v < NVEC; v++) begin
      wrMac = VEC[v][69:22]; wrVid = VEC[v][21:10];
      wrPortMap = VEC[v][9:2]; wrStatus = VEC[v][1:0];
      issue(C_WR, int'(VEC[v][72:70]), cyc);
      chk("R3 write busy", cyc, 1);
    end
    for (int v = 0; v < NVEC; v++) begin
      issue(C_RD, int'(VEC[v][72:70]), cyc);
      chk("R3 read busy", cyc, 1);
      chk("R5 mac", rdMac, VEC[v][69:22]);
      chk("R5 vid", rdVid, VEC[v][21:10]);
      chk("R5 portmap", rdPortMap, VEC[v][9:2]);
      chk("R5 status", rdStatus, VEC[v][1:0]);
      chk("R5 fid", rdFid, 3'd5);
      chk("R5 ivl", rdIvl, 1);
      chk("R5 age", rdAge, 8'h20);
      chk("R5 index", resIndex, VEC[v][72:70]);
      chk("R5 valid", invalidFlag, 0);
    end
    issue(C_RD, 0, cyc);
    chk("R5 empty read invalid", invalidFlag, 1);

    issue(4'd3, 1, cyc);
    chk("R2 unknown invalid", invalidFlag, 1);
    chk("R2 unknown busy", cyc, 1);
    issue(C_RD, 1, cyc);
    chk("R2 table intact", rdMac, 48'h0011_2233_4455);

    issue(C_ST, 0, cyc);
    chk("R6 first hit", searchHit, 1);
    chk("R6 first index", resIndex, 1);
    chk("R6 scan cycles", cyc, 2);
    chk("R6 hit entry", rdMac, 48'h0011_2233_4455);
    issue(C_NX, 0, cyc);
    chk("R7 next index 3", resIndex, 3);
    chk("R7 next cycles", cyc, 2);
    issue(C_NX, 0, cyc);
    chk("R7 next index 4", resIndex, 4);
    issue(C_NX, 0, cyc);
    chk("R7 next index 6", resIndex, 6);
    chk("R7 next hit", searchHit, 1);
    issue(C_NX, 0, cyc);
    chk("R7 end flag", searchEnd, 1);
    chk("R7 end no hit", searchHit, 0);
    chk("R7 end cycles", cyc, 2);

    // R4: write presented while search-start is busy
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = C_ST; cmdIndex = '0;
    @(negedge clk);
    cmdCode = C_WR; cmdIndex = 3'd0; wrStatus = 2'd1; wrMac = 48'h1;
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy) @(negedge clk);
    chk("R4 search still done", resIndex, 1);
    issue(C_RD, 0, cyc);
    chk("R4 busy write ignored", invalidFlag, 1);

    // ageing: reload idx1 with short timer
    ageCount = 8'd2; wrMac = 48'h0011_2233_4455; wrVid = 12'h00A;
    wrPortMap = 8'h03; wrStatus = 2'd1;
    issue(C_WR, 1, cyc);
    ageCount = 8'h20;
    repeat (40) @(negedge clk);
    issue(C_RD, 4, cyc);
    chk("R10 disabled no ageing", rdAge, 8'h20);
    issue(C_RD, 1, cyc);
    chk("R10 disabled short entry kept", rdStatus, 2'd1);
    @(negedge clk);
    ageDisable = 1'b0;
    repeat (20) @(negedge clk);
    ageDisable = 1'b1;
    issue(C_RD, 1, cyc);
    chk("R9 expired invalid", invalidFlag, 1);
    chk("R9 expired status", rdStatus, 0);
    issue(C_RD, 4, cyc);
    chk("R9 age decremented idx4", rdAge, 8'd27);
    issue(C_RD, 6, cyc);
    chk("R9 age decremented idx6", rdAge, 8'd27);
    issue(C_RD, 3, cyc);
    chk("R9 static age kept", rdAge, 8'h20);
    chk("R9 static status kept", rdStatus, 2'd3);

    issue(C_FL, 0, cyc);
    chk("R8 flush busy", cyc, ENTRIES);
    issue(C_RD, 3, cyc);
    chk("R8 static survives", rdStatus, 2'd3);
    chk("R11 flags after read", {searchHit, searchEnd}, 2'b00);
    issue(C_RD, 4, cyc);
    chk("R8 dynamic flushed", invalidFlag, 1);
    issue(C_RD, 6, cyc);
    chk("R8 dynamic flushed idx6", invalidFlag, 1);
    issue(C_ST, 0, cyc);
    chk("R6 only static left", resIndex, 3);
    chk("R11 hit without end", {searchHit, searchEnd}, 2'b10);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule